// File: doc/BRIEF.md
# Debounced Video Address Edge Event Generator

This block watches one line of the video memory address bus, bit 12 of a 16-bit address, and turns a selected transition of that line into a one-cycle event pulse. A downstream scanline counter or interrupt unit consumes the pulse. The line is sampled only when an address-update strobe arrives, and the last sampled value is kept so that the next sample can be compared with it. A polarity input picks which transition counts: low-to-high or high-to-low.

Fetch patterns can make the line bounce several times within a few video cycles, so the block keeps a gap counter. The counter advances once per video clock enable and saturates. A qualifying transition produces an event only when more than eight enables have passed since the previous qualifying transition or since reset. Every qualifying transition restarts the gap, whether or not it fired. A block enable freezes the whole unit when it is low: strobes are not sampled, the gap counter holds and no event is produced.

Top module: `addr_edge_filter`

## Requirements
- R1: After reset the event output is 0, the stored line value is 0 and the gap count is 0. A qualifying low-to-high strobe right after reset, with no clock enables in between, therefore produces no event.
- R2: Only address bit 12 is compared. Changing any other address bit on a strobe never produces an event.
- R3: With `riseSel` = 1, only a change of bit 12 from 0 to 1 qualifies. With `riseSel` = 0, only a change from 1 to 0 qualifies. The opposite change never produces an event.
- R4: The gap count rises by one on each cycle where `vidCe` = 1 and the block is enabled. It saturates at 2^CNT_W-1 (255 by default) and does not wrap, so 261 enables still allow the next qualifying edge to fire.
- R5: A qualifying edge fires only when the gap count exceeds 8. Exactly 8 enables since the last qualifying edge gives no event; 9 enables gives an event.
- R6: Every qualifying edge clears the gap count to 0, including one whose event was suppressed. A clock enable in the same cycle as the qualifying strobe is not counted.
- R7: While `blkEn` = 0, strobes do not update the stored line value, clock enables do not advance the gap count, and no event is produced.
- R8: An event is a single-cycle high on `evtPulse`, in the cycle right after the cycle that carries the qualifying strobe.
- R9: An enabled strobe that does not qualify, whether an opposite change or no change of bit 12, still updates the stored line value but leaves the gap count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| vidCe | input | 1 | Video clock enable; one gap-count step per high cycle |
| addrStb | input | 1 | Address-update strobe; samples `addr` |
| addr | input | 16 | Video memory address |
| blkEn | input | 1 | Block enable |
| riseSel | input | 1 | 1: low-to-high qualifies; 0: high-to-low qualifies |
| evtPulse | output | 1 | One-cycle event pulse |

## Verification
The internal state is only a stored line bit and a gap count, so a wrong value of either shows up as a missing or extra `evtPulse` on the next qualifying strobe, one cycle after that strobe. A wrong stored bit turns a same-level strobe into an edge, or hides a real edge. A count that fails to clear, wraps, or advances while disabled moves the 8/9 threshold. The vectors are therefore arranged so that each such fault flips the expected pulse on the very next strobe.

// File: rtl/addr_edge_pkg.sv
package addr_edge_pkg;

  // Strobes from control to datapath, valid for one cycle each
  typedef struct packed {
    logic sample;    // capture the watched address bit
    logic tick;      // advance the gap count
    logic clearGap;  // qualifying edge seen: restart the gap
    logic fire;      // qualifying edge with enough gap: emit event
  } edge_ctl_t;

endpackage

// File: rtl/edge_ctl.sv
module edge_ctl
  import addr_edge_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int WATCH_BIT = 12
) (
  input  logic              vidCe,
  input  logic              addrStb,
  input  logic [ADDR_W-1:0] addr,
  input  logic              blkEn,
  input  logic              riseSel,
  input  logic              levelBit,
  input  logic              gapOk,
  output logic              newBit,
  output edge_ctl_t         ctl
);

  logic sampleNow;
  logic risingSeen;
  logic fallingSeen;
  logic qualEdge;

  always_comb begin
    newBit      = addr[WATCH_BIT];
    sampleNow   = blkEn & addrStb;
    risingSeen  = ~levelBit & newBit;
    fallingSeen = levelBit & ~newBit;
    qualEdge    = sampleNow & (riseSel ? risingSeen : fallingSeen);

    ctl.sample   = sampleNow;
    ctl.tick     = blkEn & vidCe;
    ctl.clearGap = qualEdge;
    ctl.fire     = qualEdge & gapOk;
  end

endmodule

// File: rtl/edge_dp.sv
module edge_dp
  import addr_edge_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int MIN_GAP = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  edge_ctl_t ctl,
  input  logic      newBit,
  output logic      levelBit,
  output logic      gapOk,
  output logic      evtPulse
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] GAP_LIM = CNT_W'(MIN_GAP);

  logic [CNT_W-1:0] gapCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapCnt <= '0;
    end else if (ctl.clearGap) begin
      gapCnt <= '0;
    end else if (ctl.tick && (gapCnt != CNT_MAX)) begin
      gapCnt <= gapCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      levelBit <= 1'b0;
    end else if (ctl.sample) begin
      levelBit <= newBit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evtPulse <= 1'b0;
    end else begin
      evtPulse <= ctl.fire;
    end
  end

  always_comb gapOk = (gapCnt > GAP_LIM);

  AST_GAP_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clearGap |=> (gapCnt == '0)); // R6
  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rstN)
    ((gapCnt == CNT_MAX) && !ctl.clearGap) |=> (gapCnt == CNT_MAX)); // R4
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.tick && !ctl.clearGap) |=> $stable(gapCnt)); // R7
  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.sample |=> $stable(levelBit)); // R7
  AST_EVT_GAP: assert property (@(posedge clk) disable iff (!rstN)
    evtPulse |-> ($past(gapCnt) > GAP_LIM)); // R5

endmodule

// File: rtl/addr_edge_filter.sv
module addr_edge_filter
  import addr_edge_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int WATCH_BIT = 12,
  parameter int CNT_W     = 8,
  parameter int MIN_GAP   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              vidCe,
  input  logic              addrStb,
  input  logic [ADDR_W-1:0] addr,
  input  logic              blkEn,
  input  logic              riseSel,
  output logic              evtPulse
);

  edge_ctl_t ctl;
  logic      levelBit;
  logic      gapOk;
  logic      newBit;

  edge_ctl #(
    .ADDR_W   (ADDR_W),
    .WATCH_BIT(WATCH_BIT)
  ) i_ctl (
    .vidCe   (vidCe),
    .addrStb (addrStb),
    .addr    (addr),
    .blkEn   (blkEn),
    .riseSel (riseSel),
    .levelBit(levelBit),
    .gapOk   (gapOk),
    .newBit  (newBit),
    .ctl     (ctl)
  );

  edge_dp #(
    .CNT_W  (CNT_W),
    .MIN_GAP(MIN_GAP)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .newBit  (newBit),
    .levelBit(levelBit),
    .gapOk   (gapOk),
    .evtPulse(evtPulse)
  );

  AST_EVT_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    evtPulse |-> $past(addrStb && blkEn)); // R8
  AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    evtPulse |=> !evtPulse); // R8
  AST_EVT_POLARITY: assert property (@(posedge clk) disable iff (!rstN)
    evtPulse |-> ($past(addr[WATCH_BIT]) == $past(riseSel))); // R3

endmodule

// File: tb/test_addr_edge_filter.sv
`timescale 1ns/1ps
module test_addr_edge_filter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        vidCe = 1'b0;
  logic        addrStb = 1'b0;
  logic [15:0] addr = '0;
  logic        blkEn = 1'b0;
  logic        riseSel = 1'b1;
  logic        evtPulse;

  int nChk = 0;
  int nBad = 0;

  always #2 clk = ~clk;

  addr_edge_filter i_addr_edge_filter (
    .clk     (clk),
    .rstN    (rstN),
    .vidCe   (vidCe),
    .addrStb (addrStb),
    .addr    (addr),
    .blkEn   (blkEn),
    .riseSel (riseSel),
    .evtPulse(evtPulse)
  );

  // Row: {req[3:0], ticks[15:0], riseSel, addr[15:0], expected}
  localparam int NV = 12;
  localparam logic [37:0] VEC [NV] = '{
    {4'd6, 16'd0,  1'b1, 16'h1000, 1'b0}, // R1 R6: count 0 after reset, edge suppressed, count cleared
    {4'd3, 16'd8,  1'b1, 16'h0000, 1'b0}, // R3: falling ignored when rising selected
    {4'd5, 16'd0,  1'b1, 16'h1000, 1'b0}, // R5: count 8 is not enough
    {4'd3, 16'd0,  1'b1, 16'h0000, 1'b0}, // R3: falling again ignored
    {4'd5, 16'd9,  1'b1, 16'h1000, 1'b1}, // R5: count 9 fires
    {4'd3, 16'd20, 1'b1, 16'hEFFF, 1'b0}, // R3: falling ignored
    {4'd2, 16'd0,  1'b1, 16'h0FFF, 1'b0}, // R2: other bits change, bit 12 stays 0
    {4'd9, 16'd0,  1'b1, 16'hF000, 1'b1}, // R9: count 20 survived non-qualifying strobes
    {4'd9, 16'd12, 1'b1, 16'h1FFF, 1'b0}, // R9: same level, no edge
    {4'd3, 16'd0,  1'b0, 16'h0000, 1'b1}, // R3: falling selected, count 12
    {4'd3, 16'd10, 1'b0, 16'h1000, 1'b0}, // R3: rising ignored when falling selected
    {4'd9, 16'd0,  1'b0, 16'h0000, 1'b1}  // R9: count 10 kept through rising strobe
  };

  task automatic check(input logic act, input logic exp, input string tag);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: act=%0b exp=%0b", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      vidCe = 1'b1;
    end
    @(negedge clk);
    vidCe = 1'b0;
  endtask

  // Strobe for one cycle; the event shows one cycle later and is gone the next (R8)
  task automatic strobe(input logic [15:0] a, input logic sameTick,
                        input logic exp, input string tag);
    @(negedge clk);
    addrStb = 1'b1;
    addr    = a;
    vidCe   = sameTick;
    @(negedge clk);
    addrStb = 1'b0;
    vidCe   = 1'b0;
    check(evtPulse, exp, tag);
    @(negedge clk);
    check(evtPulse, 1'b0, {tag, " R8 pulse width"});
  endtask

  initial begin
    #(200000 * 4);
    nBad++;
    $display("FAIL R8 watchdog: act=hung exp=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN  = 1'b1;
    blkEn = 1'b1;
    @(negedge clk);
    check(evtPulse, 1'b0, "R1 reset output");

    for (int v = 0; v < NV; v++) begin
      riseSel = VEC[v][17];
      ticks(int'(VEC[v][33:18]));
      strobe(VEC[v][16:1], 1'b0, VEC[v][0],
             $sformatf("R%0d table row %0d", VEC[v][37:34], v));
    end

    // R4: 261 enables saturate at 255 and still qualify; a wrapping count would be 5
    riseSel = 1'b1;
    ticks(261);
    strobe(16'h1000, 1'b0, 1'b1, "R4 saturation");

    // R7 part A: count holds while disabled (5 counted, 10 not)
    strobe(16'h0000, 1'b0, 1'b0, "R9 falling resample");
    ticks(5);
    blkEn = 1'b0;
    ticks(10);
    strobe(16'h1000, 1'b0, 1'b0, "R7 strobe while disabled");
    blkEn = 1'b1;
    strobe(16'h1000, 1'b0, 1'b0, "R7 count held at 5");

    // R7 part B: a disabled strobe does not change the stored bit (stays 1)
    ticks(9);
    blkEn = 1'b0;
    strobe(16'h0000, 1'b0, 1'b0, "R7 disabled falling strobe");
    blkEn = 1'b1;
    strobe(16'h1000, 1'b0, 1'b0, "R7 stored bit kept");

    // R6: enable in the same cycle as a qualifying edge is not counted
    strobe(16'h0000, 1'b0, 1'b0, "R9 falling resample 2");
    strobe(16'h1000, 1'b1, 1'b1, "R6 fire with same-cycle enable");
    ticks(8);
    strobe(16'h0000, 1'b0, 1'b0, "R9 falling resample 3");
    strobe(16'h1000, 1'b0, 1'b0, "R6 same-cycle enable not counted");

    // R1: reset clears stored bit and count
    rstN = 1'b0;
    @(negedge clk);
    check(evtPulse, 1'b0, "R1 output during reset");
    rstN = 1'b1;
    riseSel = 1'b0;
    ticks(20);
    strobe(16'h0000, 1'b0, 1'b0, "R1 stored bit cleared by reset");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule